// File: doc/BRIEF.md
# Single-Wire Echoing Serial Transceiver

This block is the serial port of a debug monitor that talks to a host over one shared data line. The line idles high, and either side may only pull it low. The block receives NRZ frames. Each frame has a low start bit, eight data bits sent least significant bit first, and a high stop bit. Every bit lasts a fixed number of bus clocks. After a turnaround gap, every good byte is sent back on the same line so that the host can check it.

A frame in which the start bit and all nine following bits are low is treated as a break. The block answers a break by leaving the line released (high) for the turnaround gap. It then pulls the line low for ten bit times. A frame with a low stop bit and non-zero data is a framing error and is not echoed. While the block is sending, its receiver is switched off, so it never decodes its own output.

Upstream, the block reports each received byte with a one-cycle strobe. This strobe has no back-pressure: the consumer must take `rx_data` in the cycle `rx_valid` is high. Bytes to send use a valid/ready handshake:
- `tx_valid` and `tx_data` must be held until a cycle where `tx_ready` is high.
- The byte is taken on that clock edge.
- `tx_ready` never depends on `tx_valid`.

Top module: `sw_echo_xcvr`

## Requirements
- R1: The transmitted frame is a start bit (0), data bits 0 to 7 in order, then a stop bit (1), each held for exactly BIT_CLKS cycles. A 0 is sent by asserting `line_pull_low`, and a 1 by releasing it. The line is released whenever nothing is being sent.
- R2: Let f be the first clock edge at which the line is low while receiving is allowed. Each bit is sampled mid-period through a two-stage synchronizer. `rx_valid` pulses for one cycle, with the byte on `rx_data`, in the cycle after edge f+2+BIT_CLKS/2+9·BIT_CLKS, provided the stop bit is high.
- R3: Every good byte is echoed unchanged. The echo's start bit begins exactly TURN_BITS·BIT_CLKS+1 cycles after the `rx_valid` cycle, and the line stays released until then.
- R4: A frame with data 0x00 and a low stop bit raises `break_seen` for one cycle, at the time R2 gives for `rx_valid`, and does not raise `rx_valid`. Data 0x00 with a high stop bit is an ordinary byte.
- R5: After a break, the line is left released for TURN_BITS·BIT_CLKS+1 cycles. It is then pulled low for 10·BIT_CLKS cycles and released again.
- R6: A frame with a low stop bit and non-zero data raises `frame_err` for one cycle and is not echoed. The receiver does not rearm until the line has returned high, after which the next frame is received normally.
- R7: While an echo, a break answer or an upstream byte is pending or being sent, no `rx_valid`, `break_seen` or `frame_err` is raised, even though the block's own output is on the line.
- R8: `tx_ready` is high only when the block is idle and the synchronized line is high.
  - A byte accepted at an edge starts its start bit in the next cycle.
  - `tx_ready` stays low through the cycle after edge L+10·BIT_CLKS, where L is the accepting edge.
  - `tx_ready` is high again in the cycle after that.
- R9: With `rst_n` low at a clock edge, the block releases the line, drops every strobe and abandons any transfer. After reset it is idle with `tx_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_in | input | 1 | Level seen on the shared data line |
| line_pull_low | output | 1 | 1 pulls the shared line low, 0 releases it |
| rx_valid | output | 1 | One-cycle strobe: good byte received |
| rx_data | output | 8 | Received byte, valid while rx_valid is high |
| break_seen | output | 1 | One-cycle strobe: break received |
| frame_err | output | 1 | One-cycle strobe: bad stop bit on non-zero data |
| tx_valid | input | 1 | Upstream has a byte to send |
| tx_ready | output | 1 | Block accepts the byte at this edge |
| tx_data | input | 8 | Byte to send |

## Verification
The bench builds the block with BIT_CLKS = 16 and TURN_BITS = 2. A frame then takes 160 cycles, so many full receive–turnaround–echo exchanges fit in a short run. The cycle-exact sample point (BIT_CLKS/2 = 8), the 33-cycle turnaround and the 10-bit break answer can all be predicted and compared on every clock. With these values, the gaps between the host releasing its break and the block's answer are short enough to show that the line really sits high in between.

// File: rtl/sw_echo_pkg.sv
package sw_echo_pkg;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_BITS,
    RX_DRAIN
  } rx_state_e;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_TURN,
    SEQ_SEND
  } seq_state_e;

  localparam int FRAME_BITS = 10;
  localparam int BREAK_BITS = 11;
  localparam int PAT_W      = 11;

  function automatic logic [PAT_W-1:0] byte_frame(input logic [7:0] d);
    return {2'b11, d, 1'b0};
  endfunction

endpackage

// File: rtl/sw_echo_rx.sv
module sw_echo_rx
  import sw_echo_pkg::*;
#(
  parameter int BIT_CLKS = 278
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       line_in,
  output logic       quiet,
  output logic       byte_stb,
  output logic       brk_stb,
  output logic       ferr_stb,
  output logic [7:0] byte_out
);

  localparam int HALF  = BIT_CLKS / 2;
  localparam int FIRST = BIT_CLKS + HALF - 1;
  localparam int CW    = $clog2(FIRST + 1);

  logic [1:0]  sync_q;
  logic        ln;
  rx_state_e   st_q;
  logic [CW-1:0] wait_q;
  logic [3:0]  idx_q;
  logic [7:0]  sh_q;

  assign ln    = sync_q[1];
  assign quiet = (st_q == RX_IDLE) && ln;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q   <= 2'b11;
      st_q     <= RX_IDLE;
      wait_q   <= '0;
      idx_q    <= '0;
      sh_q     <= '0;
      byte_stb <= 1'b0;
      brk_stb  <= 1'b0;
      ferr_stb <= 1'b0;
      byte_out <= '0;
    end else begin
      sync_q   <= {sync_q[0], line_in};
      byte_stb <= 1'b0;
      brk_stb  <= 1'b0;
      ferr_stb <= 1'b0;
      if (!en) begin
        st_q <= RX_IDLE;
      end else begin
        case (st_q)
          RX_IDLE: begin
            if (!ln) begin
              st_q   <= RX_BITS;
              wait_q <= CW'(FIRST);
              idx_q  <= '0;
            end
          end
          RX_BITS: begin
            if (wait_q != '0) begin
              wait_q <= wait_q - 1'b1;
            end else begin
              wait_q <= CW'(BIT_CLKS - 1);
              if (idx_q != 4'd8) begin
                sh_q  <= {ln, sh_q[7:1]};
                idx_q <= idx_q + 4'd1;
              end else if (ln) begin
                byte_stb <= 1'b1;
                byte_out <= sh_q;
                st_q     <= RX_IDLE;
              end else if (sh_q == 8'h00) begin
                brk_stb <= 1'b1;
                st_q    <= RX_DRAIN;
              end else begin
                ferr_stb <= 1'b1;
                st_q     <= RX_DRAIN;
              end
            end
          end
          RX_DRAIN: begin
            if (ln) st_q <= RX_IDLE;
          end
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end

  // R6
  drain_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_DRAIN && !ln && en) |=> (st_q == RX_DRAIN));

endmodule

// File: rtl/sw_echo_tx.sv
module sw_echo_tx
  import sw_echo_pkg::*;
#(
  parameter int BIT_CLKS = 278
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PAT_W-1:0] pattern,
  input  logic [3:0]       nbits,
  output logic             busy,
  output logic             pull_low
);

  localparam int CW = $clog2(BIT_CLKS + 1);

  logic [PAT_W-1:0] sh_q;
  logic [CW-1:0]    cnt_q;
  logic [3:0]       left_q;

  assign pull_low = busy & ~sh_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      sh_q   <= '1;
      cnt_q  <= '0;
      left_q <= '0;
    end else if (load) begin
      busy   <= 1'b1;
      sh_q   <= pattern;
      left_q <= nbits - 4'd1;
      cnt_q  <= CW'(BIT_CLKS - 1);
    end else if (busy) begin
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (left_q == '0) begin
        busy <= 1'b0;
      end else begin
        sh_q   <= {1'b1, sh_q[PAT_W-1:1]};
        left_q <= left_q - 4'd1;
        cnt_q  <= CW'(BIT_CLKS - 1);
      end
    end
  end

  // R1
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load && cnt_q != '0) |=> $stable(pull_low));

endmodule

// File: rtl/sw_echo_xcvr.sv
module sw_echo_xcvr
  import sw_echo_pkg::*;
#(
  parameter int BIT_CLKS  = 278,
  parameter int TURN_BITS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_in,
  output logic       line_pull_low,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       break_seen,
  output logic       frame_err,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic [7:0] tx_data
);

  localparam int GAP = TURN_BITS * BIT_CLKS;
  localparam int GW  = $clog2(GAP + 1);
  localparam logic [PAT_W-1:0] BRK_PAT = {1'b1, {(PAT_W-1){1'b0}}};

  seq_state_e       seq_q;
  logic [GW-1:0]    gap_q;
  logic             brk_q;
  logic [7:0]       echo_q;
  logic             quiet, byte_stb, brk_stb, ferr_stb;
  logic [7:0]       byte_out;
  logic             rx_en, tx_load, tx_busy, take_up, turn_done;
  logic [PAT_W-1:0] tx_pat;
  logic [3:0]       tx_nbits;

  assign rx_en     = (seq_q == SEQ_IDLE);
  assign tx_ready  = rx_en && quiet && !(byte_stb || brk_stb || ferr_stb);
  assign take_up   = tx_valid && tx_ready;
  assign turn_done = (seq_q == SEQ_TURN) && (gap_q == '0);
  assign tx_load   = take_up || turn_done;

  always_comb begin
    if (turn_done && brk_q) begin
      tx_pat   = BRK_PAT;
      tx_nbits = 4'(BREAK_BITS);
    end else begin
      tx_pat   = byte_frame(turn_done ? echo_q : tx_data);
      tx_nbits = 4'(FRAME_BITS);
    end
  end

  sw_echo_rx #(.BIT_CLKS(BIT_CLKS)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .line_in(line_in),
    .quiet(quiet), .byte_stb(byte_stb), .brk_stb(brk_stb),
    .ferr_stb(ferr_stb), .byte_out(byte_out)
  );

  sw_echo_tx #(.BIT_CLKS(BIT_CLKS)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(tx_load), .pattern(tx_pat),
    .nbits(tx_nbits), .busy(tx_busy), .pull_low(line_pull_low)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q  <= SEQ_IDLE;
      gap_q  <= '0;
      brk_q  <= 1'b0;
      echo_q <= '0;
    end else begin
      case (seq_q)
        SEQ_IDLE: begin
          if (byte_stb || brk_stb) begin
            seq_q  <= SEQ_TURN;
            gap_q  <= GW'(GAP - 1);
            brk_q  <= brk_stb;
            echo_q <= byte_out;
          end else if (take_up) begin
            seq_q <= SEQ_SEND;
          end
        end
        SEQ_TURN: begin
          if (gap_q == '0) seq_q <= SEQ_SEND;
          else             gap_q <= gap_q - 1'b1;
        end
        SEQ_SEND: begin
          if (!tx_busy) seq_q <= SEQ_IDLE;
        end
        default: seq_q <= SEQ_IDLE;
      endcase
    end
  end

  assign rx_valid   = byte_stb;
  assign rx_data    = byte_out;
  assign break_seen = brk_stb;
  assign frame_err  = ferr_stb;

  // R8
  accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> line_pull_low);

  // R7
  self_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_q != SEQ_IDLE) |=> !(rx_valid || break_seen || frame_err));

  // R3
  turn_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_q == SEQ_TURN) |-> !line_pull_low);

endmodule

// File: tb/sw_echo_xcvr_test.sv
module sw_echo_xcvr_test;

  localparam int N = 16;
  localparam int TB = 2;
  localparam int G = TB * N;
  localparam int H = N / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_low = 1'b0;
  logic line;
  logic line_pull_low, rx_valid, break_seen, frame_err, tx_ready;
  logic [7:0] rx_data;
  logic tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit chk_on = 1'b0;

  bit         exp_low[int];
  logic [7:0] exp_rx[int];
  bit         exp_brk[int];
  bit         exp_fe[int];

  assign line = ~(host_low | line_pull_low);

  always #5 clk = ~clk;

  sw_echo_xcvr #(.BIT_CLKS(N), .TURN_BITS(TB)) uut (
    .clk(clk), .rst_n(rst_n), .line_in(line), .line_pull_low(line_pull_low),
    .rx_valid(rx_valid), .rx_data(rx_data), .break_seen(break_seen),
    .frame_err(frame_err), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  // per-cycle reference comparison
  always @(negedge clk) begin
    if (chk_on) begin
      bit el, ev, eb, ef;
      el = exp_low.exists(cyc);
      ev = exp_rx.exists(cyc);
      eb = exp_brk.exists(cyc);
      ef = exp_fe.exists(cyc);
      check(line_pull_low === el, "R1 R3 R5 R6 line drive", int'(line_pull_low), int'(el));
      check(rx_valid === ev, "R2 R7 rx_valid", int'(rx_valid), int'(ev));
      if (ev && rx_valid === 1'b1)
        check(rx_data === exp_rx[cyc], "R2 rx_data", int'(rx_data), int'(exp_rx[cyc]));
      check(break_seen === eb, "R4 R7 break_seen", int'(break_seen), int'(eb));
      check(frame_err === ef, "R6 R7 frame_err", int'(frame_err), int'(ef));
    end
  end

  task automatic mark_frame(input int start, input logic [10:0] pat, input int nb);
    for (int k = 0; k < nb; k++)
      if (!pat[k])
        for (int t = 0; t < N; t++) exp_low[start + k * N + t] = 1'b1;
  endtask

  // host sends start, 8 data bits, stop; returns cycle of the receive strobe
  task automatic host_frame(input logic [7:0] d, input logic stop_b, output int s);
    int f;
    logic [9:0] bits;
    @(negedge clk);
    f = cyc + 1;
    s = f + 2 + H + 9 * N;
    bits = {stop_b, d, 1'b0};
    if (stop_b) begin
      exp_rx[s] = d;
      mark_frame(s + 1 + G, {2'b11, d, 1'b0}, 10);
    end else if (d == 8'h00) begin
      exp_brk[s] = 1'b1;
      mark_frame(s + 1 + G, 11'b100_0000_0000, 11);
    end else begin
      exp_fe[s] = 1'b1;
    end
    for (int j = 0; j < 10; j++) begin
      host_low = ~bits[j];
      repeat (N) @(negedge clk);
    end
    host_low = 1'b0;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic up_send(input logic [7:0] d, output int l);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data = d;
    while (tx_ready !== 1'b1) @(negedge clk);
    l = cyc + 1;
    mark_frame(l, {2'b11, d, 1'b0}, 10);
    @(negedge clk);
    tx_valid = 1'b0;
    tx_data = 8'h00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int s, l;
    logic [7:0] pats[4];
    pats[0] = 8'hA5; pats[1] = 8'h00; pats[2] = 8'hFF; pats[3] = 8'h3C;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    check(line_pull_low === 1'b0, "R9 reset line released", int'(line_pull_low), 0);
    check(tx_ready === 1'b1, "R9 reset tx_ready", int'(tx_ready), 1);
    check(rx_valid === 1'b0, "R9 reset rx_valid", int'(rx_valid), 0);
    chk_on = 1'b1;
    repeat (5) @(negedge clk);

    // R2 R3 echo of several bytes, including 0x00 with good stop (R4)
    for (int i = 0; i < 4; i++) begin
      host_frame(pats[i], 1'b1, s);
      wait_until(s + 1 + N);
      check(tx_ready === 1'b0, "R8 R7 tx_ready low during turnaround", int'(tx_ready), 0);
      check(line === 1'b1, "R3 line high in turnaround", int'(line), 1);
      wait_until(s + 1 + G + 10 * N + 4);
    end

    // R4 R5 break and its answer
    host_frame(8'h00, 1'b0, s);
    wait_until(s + 1 + N);
    check(line === 1'b1, "R5 line released before break answer", int'(line), 1);
    wait_until(s + 1 + G + 2);
    check(line === 1'b0, "R5 break answer pulls low", int'(line), 0);
    wait_until(s + 1 + G + 11 * N + 4);

    // R6 framing error, then rearm on a good byte
    host_frame(8'h5A, 1'b0, s);
    repeat (N) @(negedge clk);
    check(tx_ready === 1'b1, "R6 idle after framing error", int'(tx_ready), 1);
    host_frame(8'h96, 1'b1, s);
    wait_until(s + 1 + G + 10 * N + 4);

    // R8 upstream byte and tx_ready timing
    up_send(8'hC3, l);
    wait_until(l + 10 * N);
    check(tx_ready === 1'b0, "R8 tx_ready low at last busy cycle", int'(tx_ready), 0);
    @(negedge clk);
    check(tx_ready === 1'b1, "R8 tx_ready back high", int'(tx_ready), 1);
    up_send(8'h01, l);
    wait_until(l + 10 * N + 4);

    // R9 reset during an echo
    host_frame(8'h81, 1'b1, s);
    wait_until(s + 1 + G + 2);
    check(line_pull_low === 1'b1, "R3 echo start bit", int'(line_pull_low), 1);
    chk_on = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(line_pull_low === 1'b0, "R9 reset releases line", int'(line_pull_low), 0);
    exp_low.delete();
    exp_rx.delete();
    exp_brk.delete();
    exp_fe.delete();
    rst_n = 1'b1;
    @(negedge clk);
    chk_on = 1'b1;
    repeat (3 * N) @(negedge clk);
    check(tx_ready === 1'b1, "R9 idle after reset", int'(tx_ready), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule